// File: doc/BRIEF.md
# USB Endpoint Configuration and Data-Toggle Controller

This block is the control part of one USB device endpoint. Firmware reads and writes it through an 8-bit register port. The configuration byte it holds chooses five things:

- whether the endpoint runs in isochronous or bulk/interrupt mode;
- which direction owns the endpoint;
- whether the shared packet FIFO is split between IN and OUT;
- whether the IN side is double-buffered;
- whether the data toggle advances on every transmitted packet or only on an acknowledged one.

From the configuration and two event strobes (packet transmitted, ACK received), the block keeps the DATA0/DATA1 toggle. It also derives the address windows of the shared FIFO. For each direction it gives an enable, a base address and a length. When double buffering is on, a ping-pong select picks which half of the IN window is in use. A USB bus reset returns everything to its power-up state. Serialization, CRC, token decoding and the FIFO storage belong to neighbouring blocks.

Top module: `ep_ctrl_top`

## Requirements
- R1: After the synchronous reset `rst`, the register reads 0x00, the toggle is DATA0 (0) and the ping-pong select is 0.
- R2: Register bit positions are fixed: bit 7 is double-buffer enable, bit 6 is isochronous mode, bit 5 is direction (1 = IN, 0 = OUT), bit 3 is force-toggle and bit 2 is FIFO split. Bits 4, 1 and 0 always read 0, and data written to them is discarded.
- R3: With force-toggle clear, the toggle inverts one cycle after an `ack_rcvd` pulse. A `tx_done` pulse on its own leaves it unchanged.
- R4: With force-toggle set, the toggle inverts one cycle after each `tx_done` pulse. An `ack_rcvd` pulse on its own leaves it unchanged.
- R5: With split set, both directions are enabled. The IN window is base DEPTH/2 with length DEPTH/2. The OUT window is base 0 with length DEPTH/2. The direction bit has no effect.
- R6: With split clear, only the direction chosen by the direction bit is enabled, and it gets base 0 with length DEPTH. The other direction is disabled with length 0.
- R7: A one-cycle `bus_reset` pulse clears the register to 0x00 and the toggle and ping-pong select to 0 on the next cycle.
- R8: With double buffering set, the IN length is half of the IN window. The ping-pong select inverts on each `tx_done`. The IN base is the window base plus the ping-pong select times the half length. With double buffering clear, the select is held at 0.
- R9: `iso_mode` and `dbuf_mode` follow register bits 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset | input | 1 | USB bus reset indication, one-cycle pulse |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| tx_done | input | 1 | Data packet transmitted strobe |
| ack_rcvd | input | 1 | ACK received strobe |
| data_toggle | output | 1 | Current data toggle (0 = DATA0) |
| pp_sel | output | 1 | IN ping-pong half select |
| in_en | output | 1 | IN direction active |
| in_base | output | $clog2(DEPTH) | IN window base address |
| in_size | output | $clog2(DEPTH)+1 | IN window length |
| out_en | output | 1 | OUT direction active |
| out_base | output | $clog2(DEPTH) | OUT window base address |
| out_size | output | $clog2(DEPTH)+1 | OUT window length |
| iso_mode | output | 1 | Isochronous mode flag |
| dbuf_mode | output | 1 | Double-buffer mode flag |

## Verification
The assertions assume that `tx_done`, `ack_rcvd` and `bus_reset` are single-cycle pulses. They also assume that DEPTH is a power of two of at least 4, so that every half and quarter window is exact. The stimulus drives each strobe for exactly one clock on the falling edge. It writes the register only in cycles where the toggle expectation is easy to model. Where strobes and a write coincide, the toggle and ping-pong rules use the configuration that was in force before the write.

// File: rtl/ep_ctrl_pkg.sv
package ep_ctrl_pkg;

    // bit positions software decodes
    localparam int unsigned POS_DBUF  = 7;
    localparam int unsigned POS_ISO   = 6;
    localparam int unsigned POS_DIR   = 5;
    localparam int unsigned POS_FORCE = 3;
    localparam int unsigned POS_SPLIT = 2;

    typedef struct packed {
        logic dbuf;
        logic iso;
        logic dir_in;
        logic force_tgl;
        logic split;
    } ep_cfg_t;

    function automatic ep_cfg_t cfg_from_byte(input logic [7:0] b);
        ep_cfg_t c;
        c.dbuf      = b[POS_DBUF];
        c.iso       = b[POS_ISO];
        c.dir_in    = b[POS_DIR];
        c.force_tgl = b[POS_FORCE];
        c.split     = b[POS_SPLIT];
        return c;
    endfunction

    function automatic logic [7:0] cfg_to_byte(input ep_cfg_t c);
        logic [7:0] b;
        b            = '0;
        b[POS_DBUF]  = c.dbuf;
        b[POS_ISO]   = c.iso;
        b[POS_DIR]   = c.dir_in;
        b[POS_FORCE] = c.force_tgl;
        b[POS_SPLIT] = c.split;
        return b;
    endfunction

endpackage

// File: rtl/ep_cfg_reg.sv
module ep_cfg_reg
    import ep_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_reset,
    input  logic       we,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output ep_cfg_t    cfg
);

    ep_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst || bus_reset) begin
            cfg_q <= '0;
        end else if (we) begin
            cfg_q <= cfg_from_byte(wdata);
        end
    end

    assign cfg   = cfg_q;
    assign rdata = cfg_to_byte(cfg_q);

    assert_bus_reset_clears_R7: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> (rdata == 8'h00));

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        (we && !bus_reset) |=> (rdata == ($past(wdata) & 8'hEC)));

endmodule

// File: rtl/ep_toggle.sv
module ep_toggle (
    input  logic clk,
    input  logic rst,
    input  logic bus_reset,
    input  logic force_tgl,
    input  logic dbuf,
    input  logic tx_done,
    input  logic ack_rcvd,
    output logic toggle,
    output logic pp_sel
);

    logic advance;

    always_comb begin
        advance = force_tgl ? tx_done : ack_rcvd;
    end

    always_ff @(posedge clk) begin
        if (rst || bus_reset) begin
            toggle <= 1'b0;
            pp_sel <= 1'b0;
        end else begin
            if (advance) toggle <= ~toggle;
            if (!dbuf) pp_sel <= 1'b0;
            else if (tx_done) pp_sel <= ~pp_sel;
        end
    end

    assert_ack_flips_R3: assert property (@(posedge clk) disable iff (rst || bus_reset)
        (!force_tgl && ack_rcvd) |=> (toggle != $past(toggle)));

    assert_tx_ignored_R3: assert property (@(posedge clk) disable iff (rst || bus_reset)
        (!force_tgl && !ack_rcvd) |=> $stable(toggle));

    assert_tx_flips_R4: assert property (@(posedge clk) disable iff (rst || bus_reset)
        (force_tgl && tx_done) |=> (toggle != $past(toggle)));

    assert_pp_parked_R8: assert property (@(posedge clk) disable iff (rst || bus_reset)
        !dbuf |=> !pp_sel);

endmodule

// File: rtl/ep_fifo_map.sv
module ep_fifo_map
    import ep_ctrl_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned SZW  = AW + 1
) (
    input  logic           clk,
    input  logic           rst,
    input  ep_cfg_t        cfg,
    input  logic           pp_sel,
    output logic           in_en,
    output logic [AW-1:0]  in_base,
    output logic [SZW-1:0] in_size,
    output logic           out_en,
    output logic [AW-1:0]  out_base,
    output logic [SZW-1:0] out_size
);

    localparam logic [SZW-1:0] FULL = SZW'(DEPTH);
    localparam logic [SZW-1:0] HALF = SZW'(DEPTH / 2);

    logic [AW-1:0]  win_base;
    logic [SZW-1:0] win_size;
    logic [SZW-1:0] pp_len;

    always_comb begin
        win_base = '0;
        win_size = '0;
        in_en    = 1'b0;
        out_en   = 1'b0;
        out_base = '0;
        out_size = '0;
        if (cfg.split) begin
            in_en    = 1'b1;
            out_en   = 1'b1;
            win_base = AW'(DEPTH / 2);
            win_size = HALF;
            out_size = HALF;
        end else if (cfg.dir_in) begin
            in_en    = 1'b1;
            win_size = FULL;
        end else begin
            out_en   = 1'b1;
            out_size = FULL;
        end

        pp_len = win_size >> 1;
        if (cfg.dbuf && in_en) begin
            in_size = pp_len;
            in_base = win_base + (pp_sel ? AW'(pp_len) : AW'(0));
        end else begin
            in_size = win_size;
            in_base = win_base;
        end
    end

    assert_split_shares_R5: assert property (@(posedge clk) disable iff (rst)
        cfg.split |-> (in_en && out_en && (out_size == HALF)));

    assert_single_owner_R6: assert property (@(posedge clk) disable iff (rst)
        !cfg.split |-> (in_en != out_en));

    assert_in_fits_R8: assert property (@(posedge clk) disable iff (rst)
        in_en |-> ((SZW + 1)'(in_base) + (SZW + 1)'(in_size) <= (SZW + 1)'(DEPTH)));

endmodule

// File: rtl/ep_ctrl_top.sv
module ep_ctrl_top
    import ep_ctrl_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned SZW  = AW + 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_reset,
    input  logic           reg_we,
    input  logic [7:0]     reg_wdata,
    output logic [7:0]     reg_rdata,
    input  logic           tx_done,
    input  logic           ack_rcvd,
    output logic           data_toggle,
    output logic           pp_sel,
    output logic           in_en,
    output logic [AW-1:0]  in_base,
    output logic [SZW-1:0] in_size,
    output logic           out_en,
    output logic [AW-1:0]  out_base,
    output logic [SZW-1:0] out_size,
    output logic           iso_mode,
    output logic           dbuf_mode
);

    ep_cfg_t cfg;

    ep_cfg_reg u_reg (
        .clk       (clk),
        .rst       (rst),
        .bus_reset (bus_reset),
        .we        (reg_we),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .cfg       (cfg)
    );

    ep_toggle u_tgl (
        .clk       (clk),
        .rst       (rst),
        .bus_reset (bus_reset),
        .force_tgl (cfg.force_tgl),
        .dbuf      (cfg.dbuf),
        .tx_done   (tx_done),
        .ack_rcvd  (ack_rcvd),
        .toggle    (data_toggle),
        .pp_sel    (pp_sel)
    );

    ep_fifo_map #(.DEPTH(DEPTH)) u_map (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg),
        .pp_sel   (pp_sel),
        .in_en    (in_en),
        .in_base  (in_base),
        .in_size  (in_size),
        .out_en   (out_en),
        .out_base (out_base),
        .out_size (out_size)
    );

    assign iso_mode  = cfg.iso;
    assign dbuf_mode = cfg.dbuf;

    assert_flags_track_R9: assert property (@(posedge clk) disable iff (rst)
        (iso_mode == reg_rdata[6]) && (dbuf_mode == reg_rdata[7]));

endmodule

// File: tb/ep_ctrl_top_test.sv
module ep_ctrl_top_test;

    localparam int DEPTH = 64;
    localparam int AW    = $clog2(DEPTH);
    localparam int SZW   = AW + 1;

    logic           clk = 1'b0;
    logic           rst, bus_reset, reg_we, tx_done, ack_rcvd;
    logic [7:0]     reg_wdata, reg_rdata;
    logic           data_toggle, pp_sel, in_en, out_en, iso_mode, dbuf_mode;
    logic [AW-1:0]  in_base, out_base;
    logic [SZW-1:0] in_size, out_size;

    always #2 clk = ~clk;

    ep_ctrl_top #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .bus_reset(bus_reset),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_done(tx_done), .ack_rcvd(ack_rcvd),
        .data_toggle(data_toggle), .pp_sel(pp_sel),
        .in_en(in_en), .in_base(in_base), .in_size(in_size),
        .out_en(out_en), .out_base(out_base), .out_size(out_size),
        .iso_mode(iso_mode), .dbuf_mode(dbuf_mode)
    );

    typedef struct {
        string tag;
        int    sel;
        int    exp;
    } item_t;

    item_t q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference model state
    int m_cfg = 0;
    int m_tgl = 0;
    int m_pp  = 0;

    function automatic int actual(int sel);
        case (sel)
            0:  return int'(reg_rdata);
            1:  return int'(data_toggle);
            2:  return int'(pp_sel);
            3:  return int'(in_en);
            4:  return int'(in_base);
            5:  return int'(in_size);
            6:  return int'(out_en);
            7:  return int'(out_base);
            8:  return int'(out_size);
            9:  return int'(iso_mode);
            default: return int'(dbuf_mode);
        endcase
    endfunction

    // monitor: compare queued expectations away from the active edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            int a;
            it = q.pop_front();
            a  = actual(it.sel);
            checks++;
            if (a !== it.exp) begin
                fails++;
                $display("FAIL %s sel=%0d actual=%0d expected=%0d", it.tag, it.sel, a, it.exp);
            end
        end
    end

    task automatic push(string tag, int sel, int exp);
        item_t it;
        it.tag = tag; it.sel = sel; it.exp = exp;
        q.push_back(it);
    endtask

    task automatic expect_all(string tag);
        int split, dir, dbuf, ie, oe, wb, ws, ib, is, os;
        dbuf  = (m_cfg >> 7) & 1;
        dir   = (m_cfg >> 5) & 1;
        split = (m_cfg >> 2) & 1;
        if (split != 0) begin
            ie = 1; oe = 1; wb = DEPTH / 2; ws = DEPTH / 2; os = DEPTH / 2;
        end else if (dir != 0) begin
            ie = 1; oe = 0; wb = 0; ws = DEPTH; os = 0;
        end else begin
            ie = 0; oe = 1; wb = 0; ws = 0; os = DEPTH;
        end
        if (dbuf != 0 && ie != 0) begin
            is = ws / 2; ib = wb + m_pp * (ws / 2);
        end else begin
            is = ws; ib = wb;
        end
        push(tag, 0, m_cfg);
        push(tag, 1, m_tgl);
        push(tag, 2, m_pp);
        push(tag, 3, ie);
        push(tag, 4, ib);
        push(tag, 5, is);
        push(tag, 6, oe);
        push(tag, 7, 0);
        push(tag, 8, os);
        push(tag, 9, (m_cfg >> 6) & 1);
        push(tag, 10, dbuf);
    endtask

    // driver: one clock of stimulus, model update, then expectations
    task automatic step(bit we, int wd, bit tx, bit ack, bit br, string tag);
        @(negedge clk);
        reg_we = we; reg_wdata = 8'(wd); tx_done = tx; ack_rcvd = ack; bus_reset = br;
        if (br) begin
            m_cfg = 0; m_tgl = 0; m_pp = 0;
        end else begin
            if ((((m_cfg >> 3) & 1) != 0) ? tx : ack) m_tgl ^= 1;
            if (((m_cfg >> 7) & 1) == 0) m_pp = 0;
            else if (tx) m_pp ^= 1;
            if (we) m_cfg = wd & 8'hEC;
        end
        @(posedge clk);
        #1;
        reg_we = 0; tx_done = 0; ack_rcvd = 0; bus_reset = 0;
        expect_all(tag);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst = 1; bus_reset = 0; reg_we = 0; reg_wdata = 0; tx_done = 0; ack_rcvd = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        expect_all("R1 reset state");

        step(1, 8'hFF, 0, 0, 0, "R2 all ones write");
        step(1, 8'h13, 0, 0, 0, "R2 unused bits only");
        step(1, 8'h20, 0, 0, 0, "R6 IN owns fifo");
        step(1, 8'h00, 0, 0, 0, "R6 OUT owns fifo");

        step(0, 0, 1, 0, 0, "R3 tx alone no flip");
        step(0, 0, 0, 1, 0, "R3 ack flips");
        step(0, 0, 1, 1, 0, "R3 tx with ack flips");

        step(1, 8'h08, 0, 0, 0, "R4 force set");
        step(0, 0, 1, 0, 0, "R4 tx flips");
        step(0, 0, 0, 1, 0, "R4 ack alone no flip");
        step(0, 0, 1, 0, 0, "R4 tx flips again");

        step(1, 8'h04, 0, 0, 0, "R5 split OUT dir");
        step(1, 8'h24, 0, 0, 0, "R5 split dir ignored");

        step(1, 8'hA0, 0, 0, 0, "R8 dbuf IN full");
        step(0, 0, 1, 0, 0, "R8 pp flips");
        step(0, 0, 1, 0, 0, "R8 pp flips back");
        step(0, 0, 1, 0, 0, "R8 pp high again");
        step(1, 8'h84, 0, 0, 0, "R8 dbuf with split");
        step(0, 0, 1, 0, 0, "R8 pp in split");
        step(1, 8'h20, 0, 0, 0, "R8 dbuf off parks");
        step(0, 0, 1, 0, 0, "R8 tx without dbuf");

        step(1, 8'h40, 0, 0, 0, "R9 iso flag");
        step(1, 8'hC8, 0, 0, 0, "R9 iso and dbuf");
        step(0, 0, 1, 0, 0, "R7 prepare toggle");
        step(0, 0, 0, 0, 1, "R7 bus reset");

        @(negedge clk);
        #1;
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule